// File: doc/BRIEF.md
# I2C Command Slave Front End

This block is the bus side of a small register-based peripheral on a two-wire I2C bus. It runs on a fast system clock and oversamples both bus lines. It finds Start, Repeated Start and Stop conditions, and shifts in a 7-bit address header followed by command bytes. For every byte it received, it chooses whether to pull SDA low in the ninth clock (acknowledge) or leave the line released (refuse). The choice depends on an address match, a general-call enable, whether the memory-address/operation pair in the command is allowed, and a busy flag raised while a nonvolatile write is in progress.

Each acknowledged command byte is passed to the register file as a one-cycle strobe with the byte and a flag that marks general-call traffic. Once a byte has been refused, the block stays silent until the master issues a new Start. SDA is driven open-drain through an enable output: when it is high, the line is pulled low.

Top module: `i2c_cmd_slave`

## Requirements
- R1: SDA falling while SCL is high is a Start. From any state, including mid-byte and after a refusal, it restarts reception of an address header.
- R2: In the first byte after a Start, bits [7:1] are the address (MSB first) and bit 0 is R/W (1 = read). A header whose address equals `dev_addr` is acknowledged by driving SDA low during the ninth SCL clock.
- R3: A header whose address matches neither `dev_addr` nor an enabled general call is refused, with SDA left released.
- R4: Address 0 with R/W = 0 (general call) is acknowledged only while `gcall_en` is 1. Address 0 with R/W = 1 is never acknowledged. `dev_addr` = 0 never matches. Commands that follow an acknowledged general call are strobed with `cmd_gcall` = 1; all others are strobed with `cmd_gcall` = 0.
- R5: A header whose address begins with the 10-bit prefix 11110 is refused, even when `dev_addr` holds that value.
- R6: Command byte layout: bits [7:4] are the memory address and bits [3:2] are the operation (00 write, 01 increment, 10 decrement, 11 read). Write and read are allowed at addresses 0 to 13. Increment and decrement are allowed only at addresses 0 and 1. Any other pair is refused.
- R7: A command byte received while `nv_busy` is 1 is refused and produces no strobe.
- R8: After any refusal, later bytes are neither acknowledged nor strobed until a Start.
- R9: Each acknowledged command byte raises `cmd_stb` for exactly one cycle, together with the received byte on `cmd_byte`, in the cycle the acknowledge drive begins.
- R10: After an acknowledged command, each further byte is decoded as another command under R6 and R7.
- R11: A Stop (SDA rising while SCL is high) returns the block to idle with SDA released. Bytes clocked after it without a Start are never acknowledged.
- R12: A matching header with R/W = 1 is acknowledged. The block then releases SDA and ignores the following bytes until a Start.
- R13: The acknowledge drive starts and ends only while the synchronized SCL is low, and it is released by the end of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| dev_addr | input | 7 | Own 7-bit slave address |
| gcall_en | input | 1 | Enables the general-call acknowledge |
| nv_busy | input | 1 | Nonvolatile write cycle in progress |
| cmd_stb | output | 1 | One-cycle strobe per accepted command |
| cmd_byte | output | 8 | Accepted command byte |
| cmd_gcall | output | 1 | Command arrived under a general call |

## Verification
Each line edge passes through two synchronizer flops and then the state register. The acknowledge drive and `cmd_stb` therefore appear three system clocks after the eighth SCL falling edge, and the release appears three clocks after the ninth falling edge. The modelled master holds every SCL phase for eight system clocks. It samples the wired-AND SDA in the middle of the ninth high phase, well after the drive has settled. It checks the release one phase after the ninth falling edge. Strobes are counted on the falling clock edge, and the count and captured byte are compared only after the whole byte, including its acknowledge slot, has been clocked.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2,
        PH_IGN  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               slot;
        logic               oe;
        logic               keep;
        logic               gcall;
        logic               stb;
        logic [BYTE_W-1:0]  cbyte;
    } core_s;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], din[g]};
        end

        assign lvl[g]  = pipe_q[STAGES-1];
        assign rise[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   hdr,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              gcall_en,
    output logic              ack,
    output logic              is_gcall
);
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              ten_bit;
    logic              own;

    always_comb begin
        addr     = hdr[ADDR_W:1];
        rd       = hdr[0];
        ten_bit  = (addr[ADDR_W-1:ADDR_W-5] == 5'b11110);
        own      = (addr == dev_addr) && (addr != '0) && !ten_bit;
        is_gcall = (addr == '0) && gcall_en && !rd;
        ack      = own || is_gcall;
    end
endmodule

// File: rtl/i2c_cmd_check.sv
module i2c_cmd_check #(
    parameter logic [15:0] WR_RD_MASK = 16'h3FFF,
    parameter logic [15:0] STEP_MASK  = 16'h0003
) (
    input  logic [7:0] cmd,
    output logic       ok
);
    logic [3:0] mem;
    logic [1:0] op;

    always_comb begin
        mem = cmd[7:4];
        op  = cmd[3:2];
        unique case (op)
            2'b00, 2'b11: ok = WR_RD_MASK[mem];
            default:      ok = STEP_MASK[mem];
        endcase
    end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
    import i2c_cmd_pkg::*;
#(
    parameter logic [15:0] CMD_WR_RD_MASK = 16'h3FFF,
    parameter logic [15:0] CMD_STEP_MASK  = 16'h0003,
    parameter int          SYNC_STAGES    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [6:0]  dev_addr,
    input  logic        gcall_en,
    input  logic        nv_busy,
    output logic        cmd_stb,
    output logic [7:0]  cmd_byte,
    output logic        cmd_gcall
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [1:0] lvl, rise, fall;
    logic       scl_s, sda_s, scl_rise, scl_fall;
    logic       start_ev, stop_ev;
    logic       hdr_ack, hdr_gcall, cmd_ok;
    core_s      state_d, state_q;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign start_ev = fall[1] & scl_s;
    assign stop_ev  = rise[1] & scl_s;

    i2c_addr_match #(.ADDR_W(7)) u_match (
        .hdr     (state_q.sh),
        .dev_addr(dev_addr),
        .gcall_en(gcall_en),
        .ack     (hdr_ack),
        .is_gcall(hdr_gcall)
    );

    i2c_cmd_check #(.WR_RD_MASK(CMD_WR_RD_MASK), .STEP_MASK(CMD_STEP_MASK)) u_check (
        .cmd(state_q.sh),
        .ok (cmd_ok)
    );

    always_comb begin
        state_d     = state_q;
        state_d.stb = 1'b0;
        if (start_ev) begin
            state_d.phase = PH_ADDR;
            state_d.cnt   = '0;
            state_d.slot  = 1'b0;
            state_d.oe    = 1'b0;
        end else if (stop_ev) begin
            state_d.phase = PH_IDLE;
            state_d.cnt   = '0;
            state_d.slot  = 1'b0;
            state_d.oe    = 1'b0;
        end else if (state_q.phase == PH_ADDR || state_q.phase == PH_CMD) begin
            if (state_q.slot) begin
                if (scl_fall) begin
                    state_d.slot  = 1'b0;
                    state_d.oe    = 1'b0;
                    state_d.cnt   = '0;
                    state_d.phase = state_q.keep ? PH_CMD : PH_IGN;
                end
            end else if (scl_rise && state_q.cnt != FULL) begin
                state_d.sh  = {state_q.sh[BYTE_W-2:0], sda_s};
                state_d.cnt = state_q.cnt + 1'b1;
            end else if (scl_fall && state_q.cnt == FULL) begin
                state_d.slot = 1'b1;
                if (state_q.phase == PH_ADDR) begin
                    state_d.oe    = hdr_ack;
                    state_d.keep  = hdr_ack & ~state_q.sh[0];
                    state_d.gcall = hdr_gcall;
                end else begin
                    state_d.oe    = cmd_ok & ~nv_busy;
                    state_d.keep  = cmd_ok & ~nv_busy;
                    state_d.stb   = cmd_ok & ~nv_busy;
                    if (cmd_ok && !nv_busy) state_d.cbyte = state_q.sh;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, cnt: '0, sh: '0, slot: 1'b0, oe: 1'b0,
                         keep: 1'b0, gcall: 1'b0, stb: 1'b0, cbyte: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_oe    = state_q.oe;
    assign cmd_stb   = state_q.stb;
    assign cmd_byte  = state_q.cbyte;
    assign cmd_gcall = state_q.gcall;
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk #(
    parameter logic [15:0] WR_RD_MASK = 16'h3FFF,
    parameter logic [15:0] STEP_MASK  = 16'h0003
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic [1:0] phase,
    input logic       sda_oe,
    input logic       nv_busy,
    input logic       cmd_stb,
    input logic [7:0] cmd_byte
);
    logic allowed;
    always_comb begin
        if (cmd_byte[3:2] == 2'b00 || cmd_byte[3:2] == 2'b11)
            allowed = WR_RD_MASK[cmd_byte[7:4]];
        else
            allowed = STEP_MASK[cmd_byte[7:4]];
    end

    p_oe_rise_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);
    p_oe_fall_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_lvl);
    p_stb_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> sda_oe);
    p_stb_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    p_stb_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> allowed);
    p_stb_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !$past(nv_busy));
    p_ign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) |-> !sda_oe);
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk #(
    .WR_RD_MASK(CMD_WR_RD_MASK),
    .STEP_MASK (CMD_STEP_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (scl_s),
    .phase   (state_q.phase),
    .sda_oe  (sda_oe),
    .nv_busy (nv_busy),
    .cmd_stb (cmd_stb),
    .cmd_byte(cmd_byte)
);

// File: tb/tb_i2c_cmd_slave.sv
`timescale 1ns/1ps
module tb_i2c_cmd_slave;
    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h2E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] dev_addr = OWN;
    logic       gcall_en = 1'b0;
    logic       nv_busy = 1'b0;
    logic       cmd_stb;
    logic [7:0] cmd_byte;
    logic       cmd_gcall;

    int         n_cmp = 0;
    int         n_bad = 0;
    int         stb_cnt = 0;
    logic [7:0] stb_byte = '0;
    logic       stb_gc = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_cmd_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .dev_addr (dev_addr),
        .gcall_en (gcall_en),
        .nv_busy  (nv_busy),
        .cmd_stb  (cmd_stb),
        .cmd_byte (cmd_byte),
        .cmd_gcall(cmd_gcall)
    );

    always @(negedge clk) begin
        if (cmd_stb) begin
            stb_cnt  <= stb_cnt + 1;
            stb_byte <= cmd_byte;
            stb_gc   <= cmd_gcall;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic v, output logic smp);
        m_sda = v; qw();
        m_scl = 1'b1; qw();
        smp = sda_bus; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic start_c();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic stop_c();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
    endtask

    // returns 1 when the slave acknowledged; also checks release after slot (R13)
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
        chk("R13 released after ninth clock", int'(sda_oe), 0);
    endtask

    function automatic int exp_ok(input int a, input int op);
        if (op == 0 || op == 3) return (a <= 13) ? 1 : 0;
        return (a <= 1) ? 1 : 0;
    endfunction

    initial begin
        logic a1, a2, a3;
        int   c0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset sda_oe", int'(sda_oe), 0);
        chk("R9 reset cmd_stb", int'(cmd_stb), 0);

        // R6 sweep of every address/operation pair, R2 header ack, R9 strobe
        for (int a = 0; a < 16; a++) begin
            for (int op = 0; op < 4; op++) begin
                logic [7:0] cb;
                cb = {a[3:0], op[1:0], 2'b01};
                c0 = stb_cnt;
                start_c();
                send_byte({OWN, 1'b0}, a1);
                send_byte(cb, a2);
                stop_c();
                chk("R2 own header ack", int'(a1), 1);
                chk("R6 command ack", int'(a2), exp_ok(a, op));
                chk("R9 strobe count", stb_cnt - c0, exp_ok(a, op));
                if (exp_ok(a, op) == 1) begin
                    chk("R9 strobe byte", int'(stb_byte), int'(cb));
                    chk("R4 gcall flag clear", int'(stb_gc), 0);
                end
            end
        end

        // R3 / R8 mismatch then ignore
        c0 = stb_cnt;
        start_c();
        send_byte({7'h2F, 1'b0}, a1);
        send_byte(8'h00, a2);
        stop_c();
        chk("R3 mismatch nack", int'(a1), 0);
        chk("R8 ignored after nack", int'(a2), 0);
        chk("R8 no strobe", stb_cnt - c0, 0);

        // R4 general call sweep
        for (int en = 0; en < 2; en++) begin
            for (int rw = 0; rw < 2; rw++) begin
                gcall_en = en[0];
                c0 = stb_cnt;
                start_c();
                send_byte({7'h00, rw[0]}, a1);
                send_byte(8'h10, a2);
                stop_c();
                chk("R4 gcall header", int'(a1), (en == 1 && rw == 0) ? 1 : 0);
                chk("R4 gcall command", int'(a2), (en == 1 && rw == 0) ? 1 : 0);
                if (en == 1 && rw == 0) chk("R4 gcall flag", int'(stb_gc), 1);
                chk("R4 gcall strobes", stb_cnt - c0, (en == 1 && rw == 0) ? 1 : 0);
            end
        end
        gcall_en = 1'b0;

        // R4 dev_addr 0 never matches on its own
        dev_addr = 7'h00;
        start_c(); send_byte(8'h00, a1); stop_c();
        chk("R4 zero own address", int'(a1), 0);

        // R5 10-bit prefix
        dev_addr = 7'b1111010;
        start_c(); send_byte({7'b1111010, 1'b0}, a1); stop_c();
        chk("R5 ten-bit header", int'(a1), 0);
        dev_addr = OWN;

        // R7 busy
        nv_busy = 1'b1;
        c0 = stb_cnt;
        start_c();
        send_byte({OWN, 1'b0}, a1);
        send_byte(8'h00, a2);
        stop_c();
        nv_busy = 1'b0;
        chk("R7 header acked while busy", int'(a1), 1);
        chk("R7 command refused while busy", int'(a2), 0);
        chk("R7 no strobe while busy", stb_cnt - c0, 0);

        // R8 refusal then R1 repeated start recovers; R10 continuous commands
        c0 = stb_cnt;
        start_c();
        send_byte({OWN, 1'b0}, a1);
        send_byte(8'hF0, a2);
        send_byte(8'h00, a3);
        chk("R6 invalid cmd", int'(a2), 0);
        chk("R8 later byte ignored", int'(a3), 0);
        start_c();
        send_byte({OWN, 1'b0}, a1);
        send_byte(8'h04, a2);
        send_byte(8'h18, a3);
        stop_c();
        chk("R1 repeated start ack", int'(a1), 1);
        chk("R10 first command", int'(a2), 1);
        chk("R10 second command", int'(a3), 1);
        chk("R10 two strobes", stb_cnt - c0, 2);
        chk("R10 last byte", int'(stb_byte), 8'h18);

        // R11 stop mid-byte, then bytes without a Start
        start_c();
        send_bits({OWN, 1'b0}, 4);
        stop_c();
        m_scl = 1'b0; qw();
        send_byte({OWN, 1'b0}, a1);
        chk("R11 no ack without start", int'(a1), 0);
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();

        // R1 start mid-header
        start_c();
        send_bits(8'hFF, 3);
        start_c();
        send_byte({OWN, 1'b0}, a1);
        stop_c();
        chk("R1 start mid-byte", int'(a1), 1);

        // R12 read header
        c0 = stb_cnt;
        start_c();
        send_byte({OWN, 1'b1}, a1);
        send_byte(8'h00, a2);
        stop_c();
        chk("R12 read header ack", int'(a1), 1);
        chk("R12 following byte ignored", int'(a2), 0);
        chk("R12 no strobe", stb_cnt - c0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule